// File: doc/BRIEF.md
# SD card SPI I/O port

This block gives host software a window of eight byte-wide I/O registers through which it runs an SD card in SPI mode. Software moves one byte at a time through a data register. Writing that register sends the written byte. Reading it clocks out an all-ones byte and returns whatever the card sent back in the same exchange. A control register sets the card select line. A read-only register returns a fixed configuration byte. Five scratch bytes give software state it can keep between calls. A timeout register arms a coarse counter, and reading it back reports whether the counter has expired.

The host bus is modelled as level strobes that are synchronous to `clk`. A read or write cycle lasts for as long as its strobe stays high. Write data is taken a fixed number of clocks after the strobe rises, because the data settles later than the strobe. While an SPI exchange runs, the port raises a wait request so that the host stretches the cycle. SD command handling and card initialisation are left to host software.

Top module: `sd_spi_port`

## Requirements
- R1: The port responds only when `(io_addr & 0x0FF8) == BASE_PORT`. Address bits above bit 11 are ignored, and `io_addr[2:0]` selects the register. Any access outside the window has no effect on register state and never asserts `io_rdata_oe`.
- R2: After reset, `sd_cs_n` is 1, `sd_sclk` is 0, `io_wait` is 0, `io_rdata_oe` is 0, `io_rdata` is 0xFF, all scratch bytes are 0 and the timeout limit is 0, so offset 7 reads as 1.
- R3: A write to offset 0 sends the byte over SPI in mode 0 (clock idles low, sampled on the rising edge), MSB first, with exactly 8 clock pulses. `io_wait` stays high until the exchange ends.
- R4: A read of offset 0 sends 0xFF over SPI and then presents the 8 bits received on `sd_miso` (first bit = MSB) with `io_rdata_oe` high.
- R5: A write to offset 1 sets `sd_cs_n` from data bit 0. The new level appears only after the write strobe falls.
- R6: A read of offset 1 returns the parameter `CFG_BYTE`.
- R7: Offsets 2 to 6 are five independent read/write scratch bytes.
- R8: A write to offset 7 clears the timeout counter and loads a limit of 10 times the written value. The counter advances once every `TICK_CYCLES` clocks and saturates at the limit. A read of offset 7 returns 0x01 once the counter has reached the limit and 0x00 before that.
- R9: Write data is sampled exactly `SAMPLE_DLY` clocks after the strobe is first seen. A write strobe that falls before that point is dropped.
- R10: `io_rdata_oe` is high only during a decoded read, and while it is low `io_rdata` is 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | ADDR_W | I/O address of the current cycle |
| io_wdata | input | 8 | Write data |
| io_rd | input | 1 | Read strobe, high for the length of the cycle |
| io_wr | input | 1 | Write strobe, high for the length of the cycle |
| io_rdata | output | 8 | Read data, 0xFF when not driven |
| io_rdata_oe | output | 1 | Read data valid, port drives the bus |
| io_wait | output | 1 | Wait request, stretches the host cycle |
| sd_sclk | output | 1 | SPI clock |
| sd_mosi | output | 1 | SPI data to the card |
| sd_miso | input | 1 | SPI data from the card |
| sd_cs_n | output | 1 | Card select, active low |

## Verification
The bench changes the write data twice while the strobe is held: once before the sample point and once after it. A sampler that runs early or late therefore stores the wrong scratch value, and a strobe that is too short must leave the old value in place. The card-select write is checked while the strobe is still high as well as after it falls, so a design that applies the new level at once is caught. A card model captures the MOSI bits and drives a known response, so a design that shifts LSB first or gives the wrong pulse count returns a wrong byte. Aliased addresses with high bits set, and the first address just past the window, catch a decoder that uses the wrong mask.

// File: rtl/sdp_pkg.sv
package sdp_pkg;
  localparam int SDP_BYTE_W    = 8;
  localparam int SDP_OFF_W     = 3;
  localparam int SDP_N_SCRATCH = 5;
  localparam int SDP_TO_MULT   = 10;
  localparam int SDP_LIMIT_W   = 12;

  localparam logic [SDP_OFF_W-1:0] OFF_DATA    = 3'd0;
  localparam logic [SDP_OFF_W-1:0] OFF_CTRL    = 3'd1;
  localparam logic [SDP_OFF_W-1:0] OFF_SCR_LO  = 3'd2;
  localparam logic [SDP_OFF_W-1:0] OFF_SCR_HI  = 3'd6;
  localparam logic [SDP_OFF_W-1:0] OFF_TIMEOUT = 3'd7;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_DLY,
    ST_WR_SPI,
    ST_WR_HOLD,
    ST_RD_SPI,
    ST_RD_HOLD
  } sdp_state_e;
endpackage

// File: rtl/sdp_spi_shift.sv
module sdp_spi_shift #(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  logic [7:0] tx_byte,
  input  logic       miso,
  output logic       sclk,
  output logic       mosi,
  output logic       busy,
  output logic       done,
  output logic [7:0] rx_byte
);
  localparam int DIV_W = $clog2(HALF_DIV + 1);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);

  logic [DIV_W-1:0] div_cnt;
  logic [2:0]       bit_cnt;
  logic [7:0]       sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk    <= 1'b0;
      mosi    <= 1'b0;
      busy    <= 1'b0;
      done    <= 1'b0;
      rx_byte <= 8'h00;
      div_cnt <= '0;
      bit_cnt <= 3'd0;
      sh      <= 8'h00;
    end else begin
      done <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy    <= 1'b1;
          sh      <= tx_byte;
          mosi    <= tx_byte[7];
          bit_cnt <= 3'd0;
          div_cnt <= '0;
          sclk    <= 1'b0;
        end
      end else if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        if (!sclk) begin
          sclk    <= 1'b1;
          rx_byte <= {rx_byte[6:0], miso};
        end else begin
          sclk <= 1'b0;
          if (bit_cnt == 3'd7) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            bit_cnt <= bit_cnt + 3'd1;
            sh      <= {sh[6:0], 1'b0};
            mosi    <= sh[6];
          end
        end
      end else begin
        div_cnt <= div_cnt + DIV_W'(1);
      end
    end
  end
endmodule

// File: rtl/sdp_timeout.sv
module sdp_timeout import sdp_pkg::*; #(
  parameter int TICK_CYCLES = 125000
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [SDP_BYTE_W-1:0] load_val,
  output logic                  expired
);
  localparam int PRE_W = $clog2(TICK_CYCLES + 1);
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_CYCLES - 1);

  logic [PRE_W-1:0]       pre_cnt;
  logic                   tick;
  logic [SDP_LIMIT_W-1:0] count;
  logic [SDP_LIMIT_W-1:0] limit;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_cnt <= '0;
      tick    <= 1'b0;
    end else if (pre_cnt == PRE_LAST) begin
      pre_cnt <= '0;
      tick    <= 1'b1;
    end else begin
      pre_cnt <= pre_cnt + PRE_W'(1);
      tick    <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count <= '0;
      limit <= '0;
    end else if (load) begin
      count <= '0;
      limit <= SDP_LIMIT_W'(load_val) * SDP_LIMIT_W'(SDP_TO_MULT);
    end else if (tick && (count < limit)) begin
      count <= count + SDP_LIMIT_W'(1);
    end
  end

  assign expired = (count >= limit);
endmodule

// File: rtl/sdp_bus_ctl.sv
module sdp_bus_ctl import sdp_pkg::*; #(
  parameter int          ADDR_W     = 16,
  parameter logic [11:0] BASE_PORT  = 12'h2A0,
  parameter logic [7:0]  CFG_BYTE   = 8'h01,
  parameter int          SAMPLE_DLY = 6
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [ADDR_W-1:0]     io_addr,
  input  logic [SDP_BYTE_W-1:0] io_wdata,
  input  logic                  io_rd,
  input  logic                  io_wr,
  output logic [SDP_BYTE_W-1:0] io_rdata,
  output logic                  io_rdata_oe,
  output logic                  io_wait,
  output logic                  cs_n,
  output logic                  spi_start,
  output logic [SDP_BYTE_W-1:0] spi_tx,
  input  logic                  spi_done,
  input  logic [SDP_BYTE_W-1:0] spi_rx,
  output logic                  to_load,
  output logic [SDP_BYTE_W-1:0] to_val,
  input  logic                  to_expired
);
  localparam logic [11:0] DEC_MASK = 12'hFF8;
  localparam int          DLY_W    = $clog2(SAMPLE_DLY + 1);
  localparam logic [DLY_W-1:0] DLY_LAST = DLY_W'(SAMPLE_DLY - 1);

  sdp_state_e             state;
  logic [DLY_W-1:0]       dly_cnt;
  logic [SDP_OFF_W-1:0]   off_q;
  logic [SDP_OFF_W-1:0]   off_in;
  logic                   hit;
  logic [SDP_BYTE_W-1:0]  scratch [SDP_N_SCRATCH];
  logic [SDP_BYTE_W-1:0]  rd_mux;
  logic                   cs_pend;
  logic                   cs_pend_vld;

  assign off_in = io_addr[SDP_OFF_W-1:0];
  assign hit    = ((io_addr[11:0] & DEC_MASK) == BASE_PORT);

  always_comb begin
    rd_mux = 8'hFF;
    if (off_in == OFF_CTRL) begin
      rd_mux = CFG_BYTE;
    end else if (off_in == OFF_TIMEOUT) begin
      rd_mux = {7'd0, to_expired};
    end else if (off_in >= OFF_SCR_LO && off_in <= OFF_SCR_HI) begin
      rd_mux = scratch[off_in - OFF_SCR_LO];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      dly_cnt     <= '0;
      off_q       <= '0;
      io_rdata    <= 8'hFF;
      io_rdata_oe <= 1'b0;
      io_wait     <= 1'b0;
      cs_n        <= 1'b1;
      cs_pend     <= 1'b1;
      cs_pend_vld <= 1'b0;
      spi_start   <= 1'b0;
      spi_tx      <= 8'hFF;
      to_load     <= 1'b0;
      to_val      <= 8'h00;
      for (int i = 0; i < SDP_N_SCRATCH; i++) scratch[i] <= 8'h00;
    end else begin
      spi_start <= 1'b0;
      to_load   <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (io_wr && hit) begin
            off_q   <= off_in;
            dly_cnt <= '0;
            state   <= ST_WR_DLY;
          end else if (io_rd && hit) begin
            off_q <= off_in;
            if (off_in == OFF_DATA) begin
              spi_start <= 1'b1;
              spi_tx    <= 8'hFF;
              io_wait   <= 1'b1;
              state     <= ST_RD_SPI;
            end else begin
              io_rdata    <= rd_mux;
              io_rdata_oe <= 1'b1;
              state       <= ST_RD_HOLD;
            end
          end
        end
        ST_WR_DLY: begin
          if (!io_wr) begin
            state <= ST_IDLE;
          end else if (dly_cnt == DLY_LAST) begin
            state <= ST_WR_HOLD;
            if (off_q == OFF_DATA) begin
              spi_start <= 1'b1;
              spi_tx    <= io_wdata;
              io_wait   <= 1'b1;
              state     <= ST_WR_SPI;
            end else if (off_q == OFF_CTRL) begin
              cs_pend     <= io_wdata[0];
              cs_pend_vld <= 1'b1;
            end else if (off_q == OFF_TIMEOUT) begin
              to_load <= 1'b1;
              to_val  <= io_wdata;
            end else begin
              scratch[off_q - OFF_SCR_LO] <= io_wdata;
            end
          end else begin
            dly_cnt <= dly_cnt + DLY_W'(1);
          end
        end
        ST_WR_SPI: begin
          if (spi_done) begin
            io_wait <= 1'b0;
            state   <= ST_WR_HOLD;
          end
        end
        ST_WR_HOLD: begin
          if (!io_wr) begin
            if (cs_pend_vld) cs_n <= cs_pend;
            cs_pend_vld <= 1'b0;
            state       <= ST_IDLE;
          end
        end
        ST_RD_SPI: begin
          if (spi_done) begin
            io_wait     <= 1'b0;
            io_rdata    <= spi_rx;
            io_rdata_oe <= 1'b1;
            state       <= ST_RD_HOLD;
          end
        end
        ST_RD_HOLD: begin
          if (!io_rd) begin
            io_rdata    <= 8'hFF;
            io_rdata_oe <= 1'b0;
            state       <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sd_spi_port.sv
module sd_spi_port import sdp_pkg::*; #(
  parameter int          ADDR_W      = 16,
  parameter logic [11:0] BASE_PORT   = 12'h2A0,
  parameter logic [7:0]  CFG_BYTE    = 8'h01,
  parameter int          SAMPLE_DLY  = 6,
  parameter int          SPI_HALF    = 2,
  parameter int          TICK_CYCLES = 125000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic [7:0]        io_wdata,
  input  logic              io_rd,
  input  logic              io_wr,
  output logic [7:0]        io_rdata,
  output logic              io_rdata_oe,
  output logic              io_wait,
  output logic              sd_sclk,
  output logic              sd_mosi,
  input  logic              sd_miso,
  output logic              sd_cs_n
);
  logic                  spi_start;
  logic [SDP_BYTE_W-1:0] spi_tx;
  logic                  spi_done;
  logic                  spi_busy;
  logic [SDP_BYTE_W-1:0] spi_rx;
  logic                  to_load;
  logic [SDP_BYTE_W-1:0] to_val;
  logic                  to_expired;

  sdp_bus_ctl #(
    .ADDR_W     (ADDR_W),
    .BASE_PORT  (BASE_PORT),
    .CFG_BYTE   (CFG_BYTE),
    .SAMPLE_DLY (SAMPLE_DLY)
  ) u_ctl (
    .clk         (clk),
    .rst         (rst),
    .io_addr     (io_addr),
    .io_wdata    (io_wdata),
    .io_rd       (io_rd),
    .io_wr       (io_wr),
    .io_rdata    (io_rdata),
    .io_rdata_oe (io_rdata_oe),
    .io_wait     (io_wait),
    .cs_n        (sd_cs_n),
    .spi_start   (spi_start),
    .spi_tx      (spi_tx),
    .spi_done    (spi_done),
    .spi_rx      (spi_rx),
    .to_load     (to_load),
    .to_val      (to_val),
    .to_expired  (to_expired)
  );

  sdp_spi_shift #(
    .HALF_DIV (SPI_HALF)
  ) u_spi (
    .clk     (clk),
    .rst     (rst),
    .start   (spi_start),
    .tx_byte (spi_tx),
    .miso    (sd_miso),
    .sclk    (sd_sclk),
    .mosi    (sd_mosi),
    .busy    (spi_busy),
    .done    (spi_done),
    .rx_byte (spi_rx)
  );

  sdp_timeout #(
    .TICK_CYCLES (TICK_CYCLES)
  ) u_to (
    .clk      (clk),
    .rst      (rst),
    .load     (to_load),
    .load_val (to_val),
    .expired  (to_expired)
  );
endmodule

// File: rtl/sd_spi_port_chk.sv
module sd_spi_port_chk (
  input logic       clk,
  input logic       rst,
  input logic       io_rd,
  input logic       io_wr,
  input logic [7:0] io_rdata,
  input logic       io_rdata_oe,
  input logic       io_wait,
  input logic       sd_sclk,
  input logic       sd_mosi,
  input logic       sd_cs_n
);
  // R5: select level moves only once the write strobe has dropped
  assert_cs_after_cycle_R5: assert property (@(posedge clk) disable iff (rst)
    !$stable(sd_cs_n) |-> !$past(io_wr));

  // R3: every SPI clock pulse lies inside a wait request
  assert_sclk_in_wait_R3: assert property (@(posedge clk) disable iff (rst)
    sd_sclk |-> io_wait);

  // R3: mode 0, data held steady while the clock is high
  assert_mosi_stable_R3: assert property (@(posedge clk) disable iff (rst)
    (sd_sclk && $past(sd_sclk)) |-> $stable(sd_mosi));

  // R10: idle read bus shows all ones
  assert_idle_ff_R10: assert property (@(posedge clk) disable iff (rst)
    !io_rdata_oe |-> (io_rdata == 8'hFF));

  // R10: data valid only follows a read strobe
  assert_oe_needs_rd_R10: assert property (@(posedge clk) disable iff (rst)
    io_rdata_oe |-> $past(io_rd));

  // R4: wait and data-valid are never raised together
  assert_wait_oe_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(io_rdata_oe && io_wait));
endmodule

bind sd_spi_port sd_spi_port_chk u_sd_spi_port_chk (
  .clk         (clk),
  .rst         (rst),
  .io_rd       (io_rd),
  .io_wr       (io_wr),
  .io_rdata    (io_rdata),
  .io_rdata_oe (io_rdata_oe),
  .io_wait     (io_wait),
  .sd_sclk     (sd_sclk),
  .sd_mosi     (sd_mosi),
  .sd_cs_n     (sd_cs_n)
);

// File: tb/sd_spi_port_bench.sv
module sd_spi_port_bench;
  localparam int          ADDR_W = 16;
  localparam logic [11:0] BASE   = 12'h2A0;
  localparam logic [7:0]  CFG    = 8'h5C;
  localparam int          SDLY   = 6;
  localparam int          HALF   = 2;
  localparam int          TICK   = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [ADDR_W-1:0] io_addr = '0;
  logic [7:0]        io_wdata = 8'h00;
  logic              io_rd = 1'b0;
  logic              io_wr = 1'b0;
  logic [7:0]        io_rdata;
  logic              io_rdata_oe;
  logic              io_wait;
  logic              sd_sclk;
  logic              sd_mosi;
  logic              sd_miso;
  logic              sd_cs_n;

  int checks = 0;
  int errors = 0;

  logic [7:0] slv_sh = 8'hFF;
  logic [7:0] slv_rx = 8'h00;
  int         edges  = 0;

  always #4 clk = ~clk;

  sd_spi_port #(
    .ADDR_W (ADDR_W), .BASE_PORT (BASE), .CFG_BYTE (CFG),
    .SAMPLE_DLY (SDLY), .SPI_HALF (HALF), .TICK_CYCLES (TICK)
  ) u_sd_spi_port (
    .clk (clk), .rst (rst), .io_addr (io_addr), .io_wdata (io_wdata),
    .io_rd (io_rd), .io_wr (io_wr), .io_rdata (io_rdata),
    .io_rdata_oe (io_rdata_oe), .io_wait (io_wait), .sd_sclk (sd_sclk),
    .sd_mosi (sd_mosi), .sd_miso (sd_miso), .sd_cs_n (sd_cs_n)
  );

  // card model: captures MOSI on rising SCLK, shifts its reply on falling SCLK
  assign sd_miso = slv_sh[7];
  always @(posedge sd_sclk) begin
    slv_rx <= {slv_rx[6:0], sd_mosi};
    edges  <= edges + 1;
  end
  always @(negedge sd_sclk) slv_sh <= {slv_sh[6:0], 1'b1};

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1'b1;
    repeat (SDLY + 2) @(negedge clk);
    for (int i = 0; i < 200 && io_wait; i++) @(negedge clk);
    io_wr = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input logic [15:0] a, output logic [7:0] d, output logic oe);
    @(negedge clk);
    io_addr = a; io_rd = 1'b1;
    oe = 1'b0;
    for (int i = 0; i < 100 && !io_rdata_oe; i++) @(negedge clk);
    oe = io_rdata_oe; d = io_rdata;
    io_rd = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [15:0] port(input int off);
    return {4'h0, BASE} + 16'(off);
  endfunction

  task automatic t_reset();
    logic [7:0] d; logic oe;
    check("R2 cs_n", sd_cs_n, 1);
    check("R2 sclk", sd_sclk, 0);
    check("R2 wait", io_wait, 0);
    check("R2 oe", io_rdata_oe, 0);
    check("R2 rdata", io_rdata, 8'hFF);
    for (int k = 2; k <= 6; k++) begin
      do_read(port(k), d, oe);
      check("R2 scratch zero", d, 8'h00);
    end
    do_read(port(7), d, oe);
    check("R2 zero limit expired", d, 8'h01);
  endtask

  task automatic t_spi_write();
    @(negedge clk);
    edges = 0;
    io_addr = port(0); io_wdata = 8'hA5; io_wr = 1'b1;
    repeat (SDLY + 3) @(negedge clk);
    check("R3 wait during exchange", io_wait, 1);
    for (int i = 0; i < 200 && io_wait; i++) @(negedge clk);
    io_wr = 1'b0;
    repeat (2) @(negedge clk);
    check("R3 byte msb first", slv_rx, 8'hA5);
    check("R3 eight clocks", edges, 8);
    check("R3 clock idle low", sd_sclk, 0);
  endtask

  task automatic t_spi_read();
    logic [7:0] d; logic oe;
    slv_sh = 8'h3C;
    edges = 0;
    do_read(port(0), d, oe);
    check("R4 oe", oe, 1);
    check("R4 received byte", d, 8'h3C);
    check("R4 sends ones", slv_rx, 8'hFF);
    check("R4 eight clocks", edges, 8);
  endtask

  task automatic t_cs();
    logic [7:0] d; logic oe;
    @(negedge clk);
    io_addr = port(1); io_wdata = 8'hFE; io_wr = 1'b1;
    repeat (SDLY + 4) @(negedge clk);
    check("R5 cs held during cycle", sd_cs_n, 1);
    io_wr = 1'b0;
    repeat (2) @(negedge clk);
    check("R5 cs low after cycle", sd_cs_n, 0);
    do_write(port(1), 8'h01);
    check("R5 cs high again", sd_cs_n, 1);
    do_read(port(1), d, oe);
    check("R6 config byte", d, CFG);
  endtask

  task automatic t_scratch();
    logic [7:0] d; logic oe;
    for (int k = 2; k <= 6; k++) do_write(port(k), 8'(8'h10 * k + k));
    for (int k = 2; k <= 6; k++) begin
      do_read(port(k), d, oe);
      check("R7 scratch", d, 8'(8'h10 * k + k));
    end
  endtask

  task automatic t_sample();
    logic [7:0] d; logic oe;
    @(negedge clk);
    io_addr = port(4); io_wdata = 8'h11; io_wr = 1'b1;
    repeat (2) @(negedge clk);
    io_wdata = 8'h5A;
    repeat (SDLY + 1) @(negedge clk);
    io_wdata = 8'h77;
    repeat (2) @(negedge clk);
    io_wr = 1'b0;
    repeat (2) @(negedge clk);
    do_read(port(4), d, oe);
    check("R9 sample point", d, 8'h5A);
    @(negedge clk);
    io_addr = port(4); io_wdata = 8'hAB; io_wr = 1'b1;
    repeat (2) @(negedge clk);
    io_wr = 1'b0;
    repeat (2) @(negedge clk);
    do_read(port(4), d, oe);
    check("R9 short strobe dropped", d, 8'h5A);
  endtask

  task automatic t_decode();
    logic [7:0] d; logic oe;
    do_read(16'hF000 | port(3), d, oe);
    check("R1 alias high bits oe", oe, 1);
    check("R1 alias high bits data", d, 8'h33);
    do_read(port(8), d, oe);
    check("R1 outside window oe", oe, 0);
    check("R10 outside window data", d, 8'hFF);
    do_write(port(8 + 3), 8'hEE);
    do_read(port(3), d, oe);
    check("R1 outside write ignored", d, 8'h33);
  endtask

  task automatic t_timeout();
    logic [7:0] d; logic oe;
    do_write(port(7), 8'd1);
    do_read(port(7), d, oe);
    check("R8 armed not expired", d, 8'h00);
    repeat (10 * TICK - 3 * SDLY) @(negedge clk);
    do_read(port(7), d, oe);
    check("R8 still counting", d, 8'h00);
    repeat (6 * TICK) @(negedge clk);
    do_read(port(7), d, oe);
    check("R8 expired", d, 8'h01);
    do_write(port(7), 8'd0);
    do_read(port(7), d, oe);
    check("R8 zero limit", d, 8'h01);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    t_reset();
    t_spi_write();
    t_spi_read();
    t_cs();
    t_scratch();
    t_sample();
    t_decode();
    t_timeout();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule